// File: doc/BRIEF.md
# NAND Flash Instruction Sequencer

This block runs a short microprogram against a raw NAND flash device on an 8-bit bus. The host presents an instruction word of eight 4-bit opcodes, a word of four command bytes, block and page addresses, a user address byte, a byte count and a few mode fields, then pulses `start`. All of these are captured at start, so they may change while the engine runs. The engine works through the opcodes one by one. Each opcode produces command-latch beats, address-latch beats or data beats, and some opcodes first wait for the device ready line.

Bulk data moves between the flash and a small internal byte buffer, which the host fills and reads through a private port. Short transfers of one or two bytes go through a 16-bit data register instead. A wait that sees the device busy for too long aborts the run and raises an error flag. The end of every run is marked by a one-cycle done pulse and a held completion flag.

Top module: `nand_seq_top`

## Requirements
- R1: Opcode slot k sits in instruction bits [31-4k:28-4k], so slot 0 occupies bits 31:28 and slot 7 occupies bits 3:0. Slots execute in order 0 to 7, and a run with no zero opcode ends after slot 7.
- R2: Opcode 0x0 ends the run in the cycle that decodes it, and no later slot executes. At the end of a run `done` is high for exactly one cycle, `busy` is low in that cycle, and `finished` then stays high until the next accepted start.
- R3: Opcodes 0x4, 0x5, 0x6 and 0x7 each emit one command beat (`fl_cle`=1, `fl_we`=1). The byte comes from `cmd_word` bits 31:24, 23:16, 15:8 or 7:0 respectively.
- R4: Opcode 0x1 emits the column address with `fl_ale`=1. With `large_page`=0 it is one beat, `page_addr[7:0]`. With `large_page`=1 it is two beats, `page_addr[7:0]` followed by `{5'b0,page_addr[10:8]}`.
- R5: Opcode 0x2 emits the row address, least significant byte first, in `addr_len`+2 beats. The row is `{blk_addr,page_addr[14:10]}` when `large_page`=0 and `{blk_addr,page_addr[17:12]}` when `large_page`=1, zero-extended.
- R6: Opcode 0x3 emits one address beat carrying `user_addr`.
- R7: Opcode 0x8 writes `byte_cnt` bytes from buffer entries 0, 1, ... onto `fl_dout` with `fl_we`=1. Opcode 0xA reads `byte_cnt` bytes with `fl_re`=1 into buffer entries 0, 1, .... A count of zero emits no beats.
- R8: Opcode 0x9 writes `short_wr[7:0]`, then also `short_wr[15:8]` when `short_two`=1. Opcode 0xB reads the first byte into `short_rd[7:0]` and clears `short_rd[15:8]`. When `short_two`=1 it then reads a second byte into `short_rd[15:8]`.
- R9: Opcodes 0xC, 0xD, 0xE and 0xF keep the bus idle until `fl_rdy` is sampled high. They then act as 0x4, 0x5, 0xA and 0xB respectively.
- R10: A wait opcode that samples `fl_rdy` low for (`tmo_sel`+1)*256 consecutive cycles aborts the run. `done` pulses in the next cycle and `timeout_err` is set. The flag stays high until the next accepted start clears it.
- R11: `start` is ignored when `run_mode` is 0 and ignored while `busy` is high.
- R12: The cycle after an accepted start is the decode cycle of slot 0. Each slot spends one idle decode cycle, then its wait cycles, then one beat per cycle. `done` rises in the cycle after the last beat or the ending decode. At most one of `fl_cle` and `fl_ale` is high, and at most one of `fl_we` and `fl_re` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse |
| run_mode | input | 2 | Engine enable; zero blocks start |
| tmo_sel | input | 4 | Wait timeout in units of 256 cycles, minus one |
| addr_len | input | 2 | Row address beats minus two |
| large_page | input | 1 | Large-page address layout |
| short_two | input | 1 | Short transfers move two bytes |
| instr_word | input | 32 | Eight packed opcodes |
| cmd_word | input | 32 | Four command bytes |
| blk_addr | input | 24 | Block address |
| page_addr | input | 18 | Page index and column |
| user_addr | input | 8 | User-defined address byte |
| byte_cnt | input | CW (5) | Bulk transfer byte count |
| short_wr | input | 16 | Short write data |
| short_rd | output | 16 | Short read data register |
| hbuf_we | input | 1 | Host buffer write enable (ignored while busy) |
| hbuf_waddr | input | AW (4) | Host buffer write address |
| hbuf_wdata | input | 8 | Host buffer write data |
| hbuf_raddr | input | AW (4) | Host buffer read address |
| hbuf_rdata | output | 8 | Host buffer read data |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we | output | 1 | Write strobe |
| fl_re | output | 1 | Read strobe |
| fl_dout | output | 8 | Flash write data |
| fl_din | input | 8 | Flash read data |
| fl_rdy | input | 1 | Device ready (high) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| finished | output | 1 | Held completion flag |
| timeout_err | output | 1 | Wait timeout abort flag |

## Verification
The hardest case to reach from the ports is the timeout abort. It needs a wait opcode to see the ready line low for hundreds of consecutive cycles, and no later slot may then run. The bench ties `fl_rdy` to a cycle threshold measured from start. Setting the threshold far out forces an abort after exactly 256 busy cycles. A threshold just inside a longer limit gives a late but successful wait. Read data comes from a per-cycle function, so every captured byte can be traced to the exact beat that took it.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECODE = 2'd1,
    ST_WAIT   = 2'd2,
    ST_XFER   = 2'd3
  } seq_state_e;

  typedef enum logic [2:0] {
    BK_CMD  = 3'd0,
    BK_COL  = 3'd1,
    BK_ROW  = 3'd2,
    BK_USR  = 3'd3,
    BK_WBUF = 3'd4,
    BK_RBUF = 3'd5,
    BK_WREG = 3'd6,
    BK_RREG = 3'd7
  } beat_kind_e;

  localparam logic [3:0] OP_END = 4'h0;

  function automatic beat_kind_e op_kind(input logic [3:0] op);
    beat_kind_e k;
    case (op)
      4'h1:                      k = BK_COL;
      4'h2:                      k = BK_ROW;
      4'h3:                      k = BK_USR;
      4'h8:                      k = BK_WBUF;
      4'h9:                      k = BK_WREG;
      4'hA, 4'hE:                k = BK_RBUF;
      4'hB, 4'hF:                k = BK_RREG;
      default:                   k = BK_CMD;
    endcase
    return k;
  endfunction

  function automatic logic op_waits(input logic [3:0] op);
    return op[3] & op[2];
  endfunction

  function automatic logic [1:0] op_cmd_sel(input logic [3:0] op);
    logic [1:0] s;
    case (op)
      4'h5, 4'hD: s = 2'd1;
      4'h6:       s = 2'd2;
      4'h7:       s = 2'd3;
      default:    s = 2'd0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/nand_seq_addr.sv
module nand_seq_addr
  import nand_seq_pkg::*;
(
  input  beat_kind_e  kind,
  input  logic [2:0]  beat_idx,
  input  logic        large_pg,
  input  logic [1:0]  row_len,
  input  logic [23:0] blk,
  input  logic [17:0] page,
  input  logic [7:0]  usr,
  output logic [7:0]  addr_byte,
  output logic [2:0]  addr_beats
);

  logic [10:0] col;
  logic [39:0] row;

  always_comb begin
    col = large_pg ? page[10:0] : {2'b00, page[8:0]};
    row = large_pg ? {10'b0, blk, page[17:12]} : {11'b0, blk, page[14:10]};
  end

  always_comb begin
    addr_byte  = 8'h00;
    addr_beats = 3'd1;
    case (kind)
      BK_COL: begin
        addr_beats = large_pg ? 3'd2 : 3'd1;
        addr_byte  = beat_idx[0] ? {5'b0, col[10:8]} : col[7:0];
      end
      BK_ROW: begin
        addr_beats = {1'b0, row_len} + 3'd2;
        case (beat_idx)
          3'd0:    addr_byte = row[7:0];
          3'd1:    addr_byte = row[15:8];
          3'd2:    addr_byte = row[23:16];
          3'd3:    addr_byte = row[31:24];
          3'd4:    addr_byte = row[39:32];
          default: addr_byte = 8'h00;
        endcase
      end
      BK_USR:  addr_byte = usr;
      default: addr_byte = 8'h00;
    endcase
  end

endmodule

// File: rtl/nand_seq_wait.sv
module nand_seq_wait #(
  parameter int TMO_W      = 4,
  parameter int TICK_SHIFT = 8,
  localparam int CNT_W     = TMO_W + TICK_SHIFT + 1
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             active,
  input  logic             rdy,
  input  logic [TMO_W-1:0] tmo,
  output logic             go,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q, cnt_d, limit_m1;

  always_comb begin
    limit_m1 = ((CNT_W'(tmo) + CNT_W'(1)) << TICK_SHIFT) - CNT_W'(1);
    go       = active & rdy;
    expire   = active & ~rdy & (cnt_q == limit_m1);
    cnt_d    = (active & ~rdy & ~expire) ? cnt_q + CNT_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R10: the busy counter never passes the programmed limit
  p_wait_bound_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    active |-> (cnt_q <= limit_m1));

  // R10: an expiry ends the wait window
  p_expire_leaves_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    expire |=> (cnt_q == '0));

endmodule

// File: rtl/nand_seq_buf.sv
module nand_seq_buf #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_a_addr,
  output logic [7:0]    rd_a_data,
  input  logic [AW-1:0] rd_b_addr,
  output logic [7:0]    rd_b_data
);

  logic [7:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic ent_en;
    assign ent_en = wr_en && (wr_addr == AW'(g));
    always_ff @(posedge clk) begin
      if (ent_en) mem[g] <= wr_data;
    end
  end

  assign rd_a_data = mem[rd_a_addr];
  assign rd_b_data = mem[rd_b_addr];

endmodule

// File: rtl/nand_seq_top.sv
module nand_seq_top
  import nand_seq_pkg::*;
#(
  parameter int BUF_DEPTH  = 16,
  parameter int TICK_SHIFT = 8,
  localparam int AW        = $clog2(BUF_DEPTH),
  localparam int CW        = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    run_mode,
  input  logic [3:0]    tmo_sel,
  input  logic [1:0]    addr_len,
  input  logic          large_page,
  input  logic          short_two,
  input  logic [31:0]   instr_word,
  input  logic [31:0]   cmd_word,
  input  logic [23:0]   blk_addr,
  input  logic [17:0]   page_addr,
  input  logic [7:0]    user_addr,
  input  logic [CW-1:0] byte_cnt,
  input  logic [15:0]   short_wr,
  output logic [15:0]   short_rd,
  input  logic          hbuf_we,
  input  logic [AW-1:0] hbuf_waddr,
  input  logic [7:0]    hbuf_wdata,
  input  logic [AW-1:0] hbuf_raddr,
  output logic [7:0]    hbuf_rdata,
  output logic          fl_cle,
  output logic          fl_ale,
  output logic          fl_we,
  output logic          fl_re,
  output logic [7:0]    fl_dout,
  input  logic [7:0]    fl_din,
  input  logic          fl_rdy,
  output logic          busy,
  output logic          done,
  output logic          finished,
  output logic          timeout_err
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ni     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ni     <= rst_meta_q;
    end
  end

  // captured run parameters
  logic [31:0]   instr_q, cmd_q;
  logic [23:0]   blk_q;
  logic [17:0]   page_q;
  logic [7:0]    usr_q;
  logic [CW-1:0] cnt_q;
  logic [15:0]   swr_q;
  logic [3:0]    tmo_q;
  logic [1:0]    alen_q;
  logic          large_q, two_q;
  logic          snap_en;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      instr_q <= '0; cmd_q  <= '0; blk_q   <= '0; page_q <= '0;
      usr_q   <= '0; cnt_q  <= '0; swr_q   <= '0; tmo_q  <= '0;
      alen_q  <= '0; large_q <= 1'b0; two_q <= 1'b0;
    end else if (snap_en) begin
      instr_q <= instr_word; cmd_q  <= cmd_word;  blk_q  <= blk_addr;
      page_q  <= page_addr;  usr_q  <= user_addr; cnt_q  <= byte_cnt;
      swr_q   <= short_wr;   tmo_q  <= tmo_sel;   alen_q <= addr_len;
      large_q <= large_page; two_q  <= short_two;
    end
  end

  // sequencer state
  seq_state_e    state_q, state_d;
  logic [2:0]    slot_q, slot_d;
  logic [CW-1:0] idx_q, idx_d, len_q, len_d;
  logic          busy_q, busy_d, done_q, done_d;
  logic          fin_q, fin_d, err_q, err_d;
  logic [15:0]   sreg_q, sreg_d;
  logic          go_adv, go_fin;

  logic [3:0]    cur_op;
  beat_kind_e    kind;
  logic [1:0]    cmd_sel;
  logic [7:0]    cmd_byte, addr_byte, buf_byte;
  logic [2:0]    addr_beats;
  logic [CW-1:0] beat_len;
  logic          in_xfer, wait_go, wait_exp;

  assign cur_op   = instr_q[{~slot_q, 2'b00} +: 4];
  assign kind     = op_kind(cur_op);
  assign cmd_sel  = op_cmd_sel(cur_op);
  assign cmd_byte = cmd_q[{~cmd_sel, 3'b000} +: 8];
  assign in_xfer  = (state_q == ST_XFER);

  nand_seq_addr u_addr (
    .kind       (kind),
    .beat_idx   (idx_q[2:0]),
    .large_pg   (large_q),
    .row_len    (alen_q),
    .blk        (blk_q),
    .page       (page_q),
    .usr        (usr_q),
    .addr_byte  (addr_byte),
    .addr_beats (addr_beats)
  );

  nand_seq_wait #(.TMO_W(4), .TICK_SHIFT(TICK_SHIFT)) u_wait (
    .clk    (clk),
    .rst_ni (rst_ni),
    .active (state_q == ST_WAIT),
    .rdy    (fl_rdy),
    .tmo    (tmo_q),
    .go     (wait_go),
    .expire (wait_exp)
  );

  // buffer: engine fill has priority, host writes only while idle
  logic          eng_we, buf_we;
  logic [AW-1:0] buf_waddr;
  logic [7:0]    buf_wdata;

  always_comb begin
    eng_we    = in_xfer && (kind == BK_RBUF);
    buf_we    = eng_we || (hbuf_we && !busy_q);
    buf_waddr = eng_we ? idx_q[AW-1:0] : hbuf_waddr;
    buf_wdata = eng_we ? fl_din : hbuf_wdata;
  end

  nand_seq_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk       (clk),
    .wr_en     (buf_we),
    .wr_addr   (buf_waddr),
    .wr_data   (buf_wdata),
    .rd_a_addr (idx_q[AW-1:0]),
    .rd_a_data (buf_byte),
    .rd_b_addr (hbuf_raddr),
    .rd_b_data (hbuf_rdata)
  );

  // beat count of the current opcode
  always_comb begin
    case (kind)
      BK_COL, BK_ROW:   beat_len = CW'(addr_beats);
      BK_WBUF, BK_RBUF: beat_len = cnt_q;
      BK_WREG, BK_RREG: beat_len = two_q ? CW'(2) : CW'(1);
      default:          beat_len = CW'(1);
    endcase
  end

  // next state
  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    idx_d   = idx_q;
    len_d   = len_q;
    busy_d  = busy_q;
    fin_d   = fin_q;
    err_d   = err_q;
    done_d  = 1'b0;
    snap_en = 1'b0;
    go_adv  = 1'b0;
    go_fin  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start && (run_mode != 2'b00)) begin
          snap_en = 1'b1;
          state_d = ST_DECODE;
          slot_d  = 3'd0;
          busy_d  = 1'b1;
          fin_d   = 1'b0;
          err_d   = 1'b0;
        end
      end
      ST_DECODE: begin
        if (cur_op == OP_END) begin
          go_fin = 1'b1;
        end else begin
          idx_d = '0;
          len_d = beat_len;
          if (op_waits(cur_op))      state_d = ST_WAIT;
          else if (beat_len == '0)   go_adv  = 1'b1;
          else                       state_d = ST_XFER;
        end
      end
      ST_WAIT: begin
        if (wait_exp) begin
          go_fin = 1'b1;
          err_d  = 1'b1;
        end else if (wait_go) begin
          if (len_q == '0) go_adv  = 1'b1;
          else             state_d = ST_XFER;
        end
      end
      ST_XFER: begin
        if (idx_q == len_q - CW'(1)) go_adv = 1'b1;
        else                         idx_d  = idx_q + CW'(1);
      end
      default: state_d = ST_IDLE;
    endcase
    if (go_adv) begin
      if (slot_q == 3'd7) begin
        go_fin = 1'b1;
      end else begin
        slot_d  = slot_q + 3'd1;
        state_d = ST_DECODE;
      end
    end
    if (go_fin) begin
      state_d = ST_IDLE;
      busy_d  = 1'b0;
      done_d  = 1'b1;
      fin_d   = 1'b1;
    end
  end

  // short read register
  always_comb begin
    sreg_d = sreg_q;
    if (in_xfer && (kind == BK_RREG)) begin
      if (idx_q == '0) sreg_d = {8'h00, fl_din};
      else             sreg_d = {fl_din, sreg_q[7:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      idx_q   <= '0;
      len_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      fin_q   <= 1'b0;
      err_q   <= 1'b0;
      sreg_q  <= '0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      idx_q   <= idx_d;
      len_q   <= len_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      fin_q   <= fin_d;
      err_q   <= err_d;
      sreg_q  <= sreg_d;
    end
  end

  // flash bus drive
  always_comb begin
    fl_cle  = in_xfer && (kind == BK_CMD);
    fl_ale  = in_xfer && (kind inside {BK_COL, BK_ROW, BK_USR});
    fl_re   = in_xfer && (kind inside {BK_RBUF, BK_RREG});
    fl_we   = in_xfer && !(kind inside {BK_RBUF, BK_RREG});
    fl_dout = 8'h00;
    if (in_xfer) begin
      case (kind)
        BK_CMD:                 fl_dout = cmd_byte;
        BK_COL, BK_ROW, BK_USR: fl_dout = addr_byte;
        BK_WBUF:                fl_dout = buf_byte;
        BK_WREG:                fl_dout = (idx_q == '0) ? swr_q[7:0] : swr_q[15:8];
        default:                fl_dout = 8'h00;
      endcase
    end
  end

  assign busy        = busy_q;
  assign done        = done_q;
  assign finished    = fin_q;
  assign timeout_err = err_q;
  assign short_rd    = sreg_q;

  // R12: latch strobes and data direction are exclusive
  p_latch_excl_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    !(fl_cle && fl_ale) && !(fl_we && fl_re));

  // R2: done lasts one cycle and coincides with busy low
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done);
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    done |-> (!busy && finished));

  // R3: a command beat is a single cycle
  p_cmd_single_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    fl_cle |=> !fl_cle);

  // R10: the error flag only appears together with the end of a run
  p_err_at_end_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(timeout_err) |-> done);

  // R11: no bus activity outside a run
  p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy |-> !(fl_we || fl_re));

endmodule

// File: tb/nand_seq_top_test.sv
module nand_seq_top_test;
  localparam int DEPTH = 16;
  localparam int AW    = 4;
  localparam int CW    = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, start, large_page, short_two, hbuf_we, fl_rdy;
  logic [1:0]    run_mode, addr_len;
  logic [3:0]    tmo_sel;
  logic [31:0]   instr_word, cmd_word;
  logic [23:0]   blk_addr;
  logic [17:0]   page_addr;
  logic [7:0]    user_addr, hbuf_wdata, hbuf_rdata, fl_dout, fl_din;
  logic [CW-1:0] byte_cnt;
  logic [15:0]   short_wr, short_rd;
  logic [AW-1:0] hbuf_waddr, hbuf_raddr;
  logic          fl_cle, fl_ale, fl_we, fl_re, busy, done, finished, timeout_err;

  nand_seq_top uut (
    .clk(clk), .rst_n(rst_n), .start(start), .run_mode(run_mode), .tmo_sel(tmo_sel),
    .addr_len(addr_len), .large_page(large_page), .short_two(short_two),
    .instr_word(instr_word), .cmd_word(cmd_word), .blk_addr(blk_addr),
    .page_addr(page_addr), .user_addr(user_addr), .byte_cnt(byte_cnt),
    .short_wr(short_wr), .short_rd(short_rd), .hbuf_we(hbuf_we),
    .hbuf_waddr(hbuf_waddr), .hbuf_wdata(hbuf_wdata), .hbuf_raddr(hbuf_raddr),
    .hbuf_rdata(hbuf_rdata), .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_we(fl_we),
    .fl_re(fl_re), .fl_dout(fl_dout), .fl_din(fl_din), .fl_rdy(fl_rdy),
    .busy(busy), .done(done), .finished(finished), .timeout_err(timeout_err)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit tb_over = 0;

  logic [13:0] exp_q [$];
  logic [7:0]  exp_buf [DEPTH];
  logic [15:0] exp_sreg = 16'h0000;
  bit          exp_err;
  int          rdy_k = 0;
  int          seed  = 3;

  function automatic logic [7:0] din_at(int c);
    return 8'((c * 37 + seed) ^ 8'h5A);
  endfunction

  function automatic bit rdy_at(int c);
    return c >= rdy_k;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // vector: {busy, done, cle, ale, we, re, dout}
  function automatic logic [13:0] vec(bit b, bit d, bit cl, bit al, bit w, bit r, logic [7:0] x);
    return {b, d, cl, al, w, r, x};
  endfunction

  // behavioural reference: builds the expected per-cycle bus trace
  task automatic model();
    int c = 0;
    int wc, n, lim;
    bit abort = 0;
    logic [3:0]  op;
    logic [39:0] row;
    logic [10:0] col;
    logic [7:0]  b;
    exp_q.delete();
    lim = (int'(tmo_sel) + 1) * 256;
    row = large_page ? {10'b0, blk_addr, page_addr[17:12]} : {11'b0, blk_addr, page_addr[14:10]};
    col = large_page ? page_addr[10:0] : {2'b0, page_addr[8:0]};
    for (int s = 0; s < 8; s++) begin
      op = instr_word[31 - 4*s -: 4];
      exp_q.push_back(vec(1, 0, 0, 0, 0, 0, 8'h00)); c++;
      if (op == 4'h0) break;
      if (op >= 4'hC) begin
        wc = 0;
        forever begin
          exp_q.push_back(vec(1, 0, 0, 0, 0, 0, 8'h00));
          if (rdy_at(c)) begin c++; break; end
          wc++; c++;
          if (wc == lim) begin abort = 1; break; end
        end
      end
      if (abort) break;
      case (op)
        4'h1:             n = large_page ? 2 : 1;
        4'h2:             n = int'(addr_len) + 2;
        4'h8, 4'hA, 4'hE: n = int'(byte_cnt);
        4'h9, 4'hB, 4'hF: n = short_two ? 2 : 1;
        default:          n = 1;
      endcase
      for (int i = 0; i < n; i++) begin
        case (op)
          4'h4, 4'hC: exp_q.push_back(vec(1, 0, 1, 0, 1, 0, cmd_word[31:24]));
          4'h5, 4'hD: exp_q.push_back(vec(1, 0, 1, 0, 1, 0, cmd_word[23:16]));
          4'h6:       exp_q.push_back(vec(1, 0, 1, 0, 1, 0, cmd_word[15:8]));
          4'h7:       exp_q.push_back(vec(1, 0, 1, 0, 1, 0, cmd_word[7:0]));
          4'h1: begin
            b = (i == 0) ? col[7:0] : {5'b0, col[10:8]};
            exp_q.push_back(vec(1, 0, 0, 1, 1, 0, b));
          end
          4'h2:       exp_q.push_back(vec(1, 0, 0, 1, 1, 0, row[8*i +: 8]));
          4'h3:       exp_q.push_back(vec(1, 0, 0, 1, 1, 0, user_addr));
          4'h8:       exp_q.push_back(vec(1, 0, 0, 0, 1, 0, exp_buf[i % DEPTH]));
          4'h9: begin
            b = (i == 0) ? short_wr[7:0] : short_wr[15:8];
            exp_q.push_back(vec(1, 0, 0, 0, 1, 0, b));
          end
          4'hA, 4'hE: begin
            exp_q.push_back(vec(1, 0, 0, 0, 0, 1, 8'h00));
            exp_buf[i % DEPTH] = din_at(c);
          end
          default: begin
            exp_q.push_back(vec(1, 0, 0, 0, 0, 1, 8'h00));
            if (i == 0) exp_sreg = {8'h00, din_at(c)};
            else        exp_sreg[15:8] = din_at(c);
          end
        endcase
        c++;
      end
    end
    exp_err = abort;
    exp_q.push_back(vec(0, 1, 0, 0, 0, 0, 8'h00));
  endtask

  // starts a run and compares the bus on every clock
  task automatic run(string tag, bit mid_start);
    model();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < exp_q.size(); c++) begin
      fl_rdy = rdy_at(c);
      fl_din = din_at(c);
      start  = mid_start && (c == 2);
      #1;
      check(tag, {busy, done, fl_cle, fl_ale, fl_we, fl_re, fl_dout}, exp_q[c]);
      @(negedge clk);
    end
    start = 1'b0;
    #1;
    check({tag, " idle after done R2"}, {busy, done, fl_we, fl_re}, 4'b0000);
    check("R2 finished held", finished, 1);
    check("R10 timeout flag", timeout_err, exp_err);
    check("R8 short register", short_rd, exp_sreg);
  endtask

  task automatic host_wr(int a, logic [7:0] d);
    @(negedge clk);
    hbuf_we = 1'b1; hbuf_waddr = AW'(a); hbuf_wdata = d;
    @(negedge clk);
    hbuf_we = 1'b0;
    exp_buf[a] = d;
  endtask

  task automatic buf_check(int a);
    hbuf_raddr = AW'(a);
    #1;
    check("R7 buffer content", hbuf_rdata, exp_buf[a]);
  endtask

  initial begin
    #1500000;
    if (!tb_over) begin
      n_bad++;
      $display("FAIL watchdog expired R12 actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; run_mode = 2'd1; tmo_sel = 4'd0; addr_len = 2'd0;
    large_page = 1'b0; short_two = 1'b0; instr_word = '0; cmd_word = 32'hA1B2C3D4;
    blk_addr = 24'hABCDEF; page_addr = 18'h37DB5; user_addr = 8'h3C; byte_cnt = '0;
    short_wr = 16'hBEEF; hbuf_we = 1'b0; hbuf_waddr = '0; hbuf_wdata = '0;
    hbuf_raddr = '0; fl_rdy = 1'b1; fl_din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    check("R2 reset outputs", {busy, done, finished, timeout_err, fl_cle, fl_ale, fl_we, fl_re}, 8'h00);
    check("R8 reset short register", short_rd, 16'h0000);

    // R3: the four command fields, ended by a no-op (R2)
    instr_word = 32'h4567_0000;
    run("R3 command fields", 0);

    // R1: all eight slots, small page (R4, R5, R6)
    instr_word = 32'h4123_5674;
    run("R1 eight slots R4 R5 R6", 0);

    // R5 large page, longest row; slots after the no-op are skipped (R2)
    large_page = 1'b1; addr_len = 2'd3;
    instr_word = 32'h1204_5000;
    run("R2 skip after end R4 R5 large", 0);
    large_page = 1'b0; addr_len = 2'd1;
    instr_word = 32'h2000_0000;
    run("R5 three row beats", 0);

    // R7: bulk write then bulk read
    for (int i = 0; i < 8; i++) host_wr(i, 8'(8'h10 + i * 3));
    byte_cnt = 5'd5;
    instr_word = 32'h48A0_0000;
    run("R7 bulk write/read", 0);
    for (int i = 0; i < 8; i++) buf_check(i);
    byte_cnt = 5'd0;
    instr_word = 32'h8A40_0000;
    run("R7 zero count", 0);

    // R8: short transfers, two bytes then one byte
    short_two = 1'b1;
    instr_word = 32'h9B00_0000;
    run("R8 short two", 0);
    short_two = 1'b0; short_wr = 16'h1234;
    instr_word = 32'h9B00_0000;
    run("R8 short one", 0);

    // R9: wait opcodes, ready rises late
    short_two = 1'b1; byte_cnt = 5'd3; rdy_k = 20; seed = 11;
    instr_word = 32'hCEFD_0000;
    run("R9 wait opcodes", 0);
    for (int i = 0; i < 3; i++) buf_check(i);

    // R10: timeout abort after 256 busy cycles, later slot never runs
    rdy_k = 100000; tmo_sel = 4'd0;
    instr_word = 32'h4C50_0000;
    run("R10 timeout abort", 0);
    // R10: longer limit, ready in time; flag cleared by the new start
    rdy_k = 400; tmo_sel = 4'd1;
    instr_word = 32'hC000_0000;
    run("R10 late ready within limit", 0);
    rdy_k = 0;

    // R11: start ignored while busy
    instr_word = 32'h4567_4560;
    run("R11 start during run", 1);

    // R11: start ignored with run_mode zero
    run_mode = 2'd0;
    instr_word = 32'h4000_0000;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    #1;
    check("R11 disabled start busy", busy, 0);
    @(negedge clk); #1;
    check("R11 disabled start bus", {busy, done, fl_cle, fl_we}, 4'b0000);
    check("R11 disabled start keeps finished", finished, 1);

    tb_over = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule